// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a task may perform an IN or OUT access to one 16-bit I/O port. A one-cycle start pulse delivers the port number, the base address of the task's state segment, and that segment's limit. The checker then reads a 16-bit pointer stored in the segment at byte offset 0x66. The pointer gives the start of a permission map that has one bit per port. The checker reads the single map byte that holds the port's bit and tests that bit. A clear bit grants the access. A set bit refuses it, and the caller raises a general-protection fault instead of completing the access.

All memory traffic goes through a byte-wide read port made of a level request, an address, a valid strobe and read data. Every decision takes exactly three reads: the low pointer byte, the high pointer byte, and the map byte. The one exception is a map byte that lies past the segment limit. In that case the map read is skipped and the access is refused. The map covers all 65536 ports, so it spans at most 8192 bytes after the pointer.

Top module: `io_perm_checker`

## Requirements
- R1: After reset, and whenever no check is in progress, `mem_req_o`, `done_o`, `allow_o` and `fault_o` are all low.
- R2: An accepted start leads to a read of byte `seg_base_i + 0x66`, which gives the low pointer byte. The next read is `seg_base_i + 0x67`, which gives the high pointer byte.
- R3: The third read is at `seg_base_i + pointer + port[15:3]`. The bit tested in the returned byte is bit number `port[2:0]`, where bit 0 is the least significant bit.
- R4: A tested bit of 1 ends the check with `fault_o` high. A tested bit of 0 ends it with `allow_o` high. For example, port 0x60 is refused exactly when map bit 0x60 is set.
- R5: `done_o` is high for exactly one cycle per accepted start. In that cycle exactly one of `allow_o` and `fault_o` is high, and neither is high in any other cycle.
- R6: If `pointer + port[15:3]` is greater than `seg_limit_i`, the map read is not issued and the check ends with `fault_o`. A value equal to the limit is still read and tested.
- R7: A start pulse that arrives while a check is in progress, including its done cycle, has no effect. It produces no extra result and does not change the result in flight.
- R8: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_valid_i` is seen. With L wait cycles per read, `done_o` rises 3(L+1) cycles after the start edge, or 2(L+1)+1 cycles after it when the limit refuses the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to check a port |
| port_i | input | 16 | I/O port number to check |
| seg_base_i | input | 32 | Base address of the task state segment |
| seg_limit_i | input | 32 | Highest valid byte offset within the segment |
| mem_req_o | output | 1 | Read request, held until valid |
| mem_addr_o | output | 32 | Byte address of the current read |
| mem_valid_i | input | 1 | Read data is present this cycle |
| mem_data_i | input | 8 | Read data byte |
| done_o | output | 1 | One-cycle end-of-check strobe |
| allow_o | output | 1 | Access granted, valid with done |
| fault_o | output | 1 | Access refused, valid with done |

## Verification
Each kind of internal error shows at the ports in its own way. A stuck or mis-stepped state machine shows up as a missing, late or duplicated `done_o`. Because the done latency is fixed by the wait count, a skipped or repeated state moves done by at least one cycle and is caught on the first check. A wrong pointer byte order or wrong port shift shows on the request address of the third read, within the same check. A wrong bit index or inverted polarity shows on `allow_o`/`fault_o` at the done cycle. A wrong limit comparison shows at the equal-to-limit boundary as a missing or extra map read.

// File: rtl/ioperm_pkg.sv
package ioperm_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PTR_LO  = 3'd1,
        ST_PTR_HI  = 3'd2,
        ST_MAP     = 3'd3,
        ST_DONE    = 3'd4
    } chk_state_e;

    typedef enum logic [1:0] {
        SEL_PTR_LO = 2'd0,
        SEL_PTR_HI = 2'd1,
        SEL_MAP    = 2'd2
    } addr_sel_e;

endpackage

// File: rtl/ioperm_addr_gen.sv
module ioperm_addr_gen
    import ioperm_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned PORT_W   = 16,
    parameter int unsigned PTR_W    = 16,
    parameter int unsigned PTR_OFS  = 32'h66,
    parameter bit          LIMIT_EN = 1'b1
) (
    input  addr_sel_e           sel_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [PTR_W-1:0]    ptr_i,
    input  logic [PORT_W-1:0]   port_i,
    input  logic [ADDR_W-1:0]   limit_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                over_o
);
    localparam int unsigned IDX_W  = $clog2(BYTE_W);
    localparam int unsigned MOFS_W = PTR_W + 1;

    logic [MOFS_W-1:0] map_off;
    logic [ADDR_W-1:0] map_off_ext;

    // Offset of the map byte inside the segment; one spare bit keeps the carry.
    assign map_off     = {1'b0, ptr_i} + MOFS_W'(port_i >> IDX_W);
    assign map_off_ext = ADDR_W'(map_off);

    always_comb begin
        case (sel_i)
            SEL_PTR_LO: addr_o = base_i + ADDR_W'(PTR_OFS);
            SEL_PTR_HI: addr_o = base_i + ADDR_W'(PTR_OFS) + ADDR_W'(1);
            SEL_MAP:    addr_o = base_i + map_off_ext;
            default:    addr_o = base_i;
        endcase
    end

    generate
        if (LIMIT_EN) begin : g_limit
            assign over_o = (map_off_ext > limit_i);
        end else begin : g_nolimit
            assign over_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ioperm_bit_sel.sv
module ioperm_bit_sel
    import ioperm_pkg::*;
#(
    parameter int unsigned PORT_W = 16
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [PORT_W-1:0] port_i,
    output logic              bit_o
);
    localparam int unsigned IDX_W = $clog2(BYTE_W);

    logic [IDX_W-1:0] idx;

    assign idx   = port_i[IDX_W-1:0];
    assign bit_o = byte_i[idx];

endmodule

// File: rtl/io_perm_checker.sv
module io_perm_checker
    import ioperm_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned PORT_W   = 16,
    parameter int unsigned PTR_OFS  = 32'h66,
    parameter bit          LIMIT_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [PORT_W-1:0]   port_i,
    input  logic [ADDR_W-1:0]   seg_base_i,
    input  logic [ADDR_W-1:0]   seg_limit_i,
    output logic                mem_req_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic                mem_valid_i,
    input  logic [BYTE_W-1:0]   mem_data_i,
    output logic                done_o,
    output logic                allow_o,
    output logic                fault_o
);
    localparam int unsigned PTR_W = 2 * BYTE_W;

    typedef struct packed {
        chk_state_e         st;
        logic [PORT_W-1:0]  port;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  limit;
        logic [PTR_W-1:0]   ptr;
        logic               deny;
    } chk_regs_t;

    chk_regs_t regs_q, regs_d;
    addr_sel_e sel;
    logic      map_over;
    logic      map_bit;

    always_comb begin
        case (regs_q.st)
            ST_PTR_HI: sel = SEL_PTR_HI;
            ST_MAP:    sel = SEL_MAP;
            default:   sel = SEL_PTR_LO;
        endcase
    end

    ioperm_addr_gen #(
        .ADDR_W   (ADDR_W),
        .PORT_W   (PORT_W),
        .PTR_W    (PTR_W),
        .PTR_OFS  (PTR_OFS),
        .LIMIT_EN (LIMIT_EN)
    ) u_addr (
        .sel_i   (sel),
        .base_i  (regs_q.base),
        .ptr_i   (regs_q.ptr),
        .port_i  (regs_q.port),
        .limit_i (regs_q.limit),
        .addr_o  (mem_addr_o),
        .over_o  (map_over)
    );

    ioperm_bit_sel #(
        .PORT_W (PORT_W)
    ) u_bit (
        .byte_i (mem_data_i),
        .port_i (regs_q.port),
        .bit_o  (map_bit)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.st    = ST_PTR_LO;
                    regs_d.port  = port_i;
                    regs_d.base  = seg_base_i;
                    regs_d.limit = seg_limit_i;
                    regs_d.ptr   = '0;
                    regs_d.deny  = 1'b0;
                end
            end
            ST_PTR_LO: begin
                if (mem_valid_i) begin
                    regs_d.ptr[BYTE_W-1:0] = mem_data_i;
                    regs_d.st              = ST_PTR_HI;
                end
            end
            ST_PTR_HI: begin
                if (mem_valid_i) begin
                    regs_d.ptr[PTR_W-1:BYTE_W] = mem_data_i;
                    regs_d.st                  = ST_MAP;
                end
            end
            ST_MAP: begin
                if (map_over) begin
                    regs_d.deny = 1'b1;
                    regs_d.st   = ST_DONE;
                end else if (mem_valid_i) begin
                    regs_d.deny = map_bit;
                    regs_d.st   = ST_DONE;
                end
            end
            ST_DONE: regs_d.st = ST_IDLE;
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_req_o = (regs_q.st == ST_PTR_LO) || (regs_q.st == ST_PTR_HI) ||
                       ((regs_q.st == ST_MAP) && !map_over);
    assign done_o    = (regs_q.st == ST_DONE);
    assign allow_o   = done_o && !regs_q.deny;
    assign fault_o   = done_o && regs_q.deny;

endmodule

// File: rtl/io_perm_checker_sva.sv
module io_perm_checker_sva #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned PTR_OFS = 32'h66
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] seg_base_i,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_valid_i,
    input logic              done_o,
    input logic              allow_o,
    input logic              fault_o
);
    logic idle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b1;
        end else if (idle_q && start_i) begin
            idle_q <= 1'b0;
        end else if (done_o) begin
            idle_q <= 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q |-> (!mem_req_o && !done_o));

    assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && start_i) |=> (mem_req_o && (mem_addr_o == $past(seg_base_i) + ADDR_W'(PTR_OFS))));

    assert_one_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (allow_o ^ fault_o));

    assert_flags_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!allow_o && !fault_o));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_no_req_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

endmodule

bind io_perm_checker io_perm_checker_sva #(
    .ADDR_W  (ADDR_W),
    .PTR_OFS (PTR_OFS)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .seg_base_i  (seg_base_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .done_o      (done_o),
    .allow_o     (allow_o),
    .fault_o     (fault_o)
);

// File: tb/tb_io_perm_checker.sv
module tb_io_perm_checker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [15:0] port_i;
    logic [31:0] seg_base_i;
    logic [31:0] seg_limit_i;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_valid_i;
    logic [7:0]  mem_data_i;
    logic        done_o;
    logic        allow_o;
    logic        fault_o;

    int tests = 0;
    int fails = 0;
    int lat   = 1;
    int wcnt  = 0;
    bit finished = 0;

    logic [7:0] mem [bit [31:0]];
    bit         exp_fault_q[$];
    string      exp_tag_q[$];
    logic [31:0] addr_log[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    io_perm_checker dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .port_i (port_i),
        .seg_base_i (seg_base_i), .seg_limit_i (seg_limit_i),
        .mem_req_o (mem_req_o), .mem_addr_o (mem_addr_o),
        .mem_valid_i (mem_valid_i), .mem_data_i (mem_data_i),
        .done_o (done_o), .allow_o (allow_o), .fault_o (fault_o)
    );

    function automatic logic [7:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction

    // Memory model: valid after lat wait cycles, data registered from address.
    always_comb mem_valid_i = mem_req_o && (wcnt == lat);

    always_ff @(posedge clk) begin
        if (mem_req_o && !mem_valid_i) wcnt <= wcnt + 1;
        else                           wcnt <= 0;
        mem_data_i <= rd(mem_addr_o);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: log handshakes, pop and compare results.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_o && mem_valid_i) addr_log.push_back(mem_addr_o);
            if (done_o) begin
                if (exp_fault_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected done", 1, 0);
                end else begin
                    automatic bit    ef  = exp_fault_q.pop_front();
                    automatic string tag = exp_tag_q.pop_front();
                    chk((fault_o == ef) && (allow_o == !ef), tag, "fault/allow",
                        {allow_o, fault_o}, {!ef, ef});
                end
            end
        end
    end

    task automatic set_ptr(input logic [31:0] base, input logic [15:0] ptr);
        mem[base + 32'h66] = ptr[7:0];
        mem[base + 32'h67] = ptr[15:8];
    endtask

    task automatic set_map(input logic [31:0] base, input logic [15:0] ptr,
                           input logic [15:0] port, input logic [7:0] val);
        mem[base + 32'(ptr) + 32'(port >> 3)] = val;
    endtask

    task automatic run(input logic [15:0] port, input logic [31:0] base,
                       input logic [31:0] limit, input int l,
                       input bit poke, input string tag);
        logic [15:0] ptr;
        logic [31:0] moff;
        bit          over, ef;
        int          n, exp_n;
        logic [7:0]  b;
        ptr   = {rd(base + 32'h67), rd(base + 32'h66)};
        moff  = 32'(ptr) + 32'(port >> 3);
        over  = moff > limit;
        b     = rd(base + moff);
        ef    = over ? 1'b1 : b[port[2:0]];
        exp_n = over ? 2*(l+1)+1 : 3*(l+1);
        lat   = l;
        addr_log.delete();
        exp_fault_q.push_back(ef);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        start_i = 1'b1; port_i = port; seg_base_i = base; seg_limit_i = limit;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start_i = poke && (n == 2);
            if (poke && n == 2) begin
                port_i = ~port; seg_base_i = base + 32'h100;
            end
            if (done_o || n > 500) break;
        end
        chk(n == exp_n, "R8", {tag, " done latency"}, n, exp_n);
        if (poke) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o, "R5", "done single cycle", done_o, 0);
        chk(addr_log.size() == (over ? 2 : 3), over ? "R6" : "R3", "read count",
            addr_log.size(), over ? 2 : 3);
        if (addr_log.size() >= 2) begin
            chk(addr_log[0] == base + 32'h66, "R2", "pointer low addr", addr_log[0], base + 32'h66);
            chk(addr_log[1] == base + 32'h67, "R2", "pointer high addr", addr_log[1], base + 32'h67);
        end
        if (!over && addr_log.size() == 3)
            chk(addr_log[2] == base + moff, "R3", "map byte addr", addr_log[2], base + moff);
        repeat (4) @(negedge clk);
        chk(exp_fault_q.size() == 0, poke ? "R7" : "R5", "result count",
            exp_fault_q.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; port_i = '0; seg_base_i = '0; seg_limit_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_o && !done_o && !allow_o && !fault_o, "R1", "reset outputs",
            {mem_req_o, done_o, allow_o, fault_o}, 0);

        // Segment A: pointer 0x0068, limit roomy.
        set_ptr(32'h0001_0000, 16'h0068);
        set_map(32'h0001_0000, 16'h0068, 16'h0060, 8'h00);
        run(16'h0060, 32'h0001_0000, 32'h0000_2100, 1, 0, "R4");
        set_map(32'h0001_0000, 16'h0068, 16'h0060, 8'h01);
        run(16'h0060, 32'h0001_0000, 32'h0000_2100, 1, 0, "R4");
        run(16'h0061, 32'h0001_0000, 32'h0000_2100, 2, 0, "R3");

        // Bit pattern sweep across one byte.
        set_map(32'h0001_0000, 16'h0068, 16'h0100, 8'hA5);
        for (int i = 0; i < 8; i++)
            run(16'h0100 + 16'(i), 32'h0001_0000, 32'h0000_2100, 1, 0, "R3");

        // Segment B: odd pointer bytes, long wait.
        set_ptr(32'h0020_0000, 16'h1A2B);
        set_map(32'h0020_0000, 16'h1A2B, 16'h1234, 8'h40);
        run(16'h1234, 32'h0020_0000, 32'h0000_FFFF, 3, 0, "R8");

        // Top port at exactly the limit, then one past it.
        set_ptr(32'h0030_0000, 16'h0100);
        set_map(32'h0030_0000, 16'h0100, 16'hFFFF, 8'h7F);
        run(16'hFFFF, 32'h0030_0000, 32'h0000_20FF, 1, 0, "R6");
        set_map(32'h0030_0000, 16'h0100, 16'hFFFF, 8'h00);
        run(16'hFFFF, 32'h0030_0000, 32'h0000_20FE, 2, 0, "R6");

        // Starts while busy are ignored.
        run(16'h0060, 32'h0001_0000, 32'h0000_2100, 2, 1, "R7");

        @(negedge clk);
        chk(!mem_req_o && !done_o, "R1", "idle after runs", {mem_req_o, done_o}, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule